// File: doc/BRIEF.md
# DMA Cache-Line Request Splitter

This block takes a single DMA transfer, described by a start byte address, a byte count and a direction, and turns it into a chain of memory transactions. Each transaction stays within one cache line. The first transaction begins at the unaligned start offset and stops at the end of that line. Every later transaction starts on a line boundary. The block issues one transaction at a time and waits for its answer before issuing the next: a store is answered by an acknowledge pulse, and a load is answered by a full line of data. The useful bytes of each returned load line are copied into a local byte buffer, which the requester reads once the transfer is done.

Only one transfer can be in progress. A request that arrives while a transfer is running is turned away with a busy status; it is not queued. The idle state is restored in the same clock edge that takes the final answer, and the completion pulse appears one cycle later. Because of this, a new request presented during the completion cycle is taken straight away. Write payloads are loaded in full with the request and are handed out line by line, each placed at the byte lanes it belongs to.

Top module: `dma_line_splitter`

## Requirements
- R1: After reset, req_ready is 1, and chk_valid, done, stat_valid and stray are all 0.
- R2: A request sampled while idle, with 1 <= req_len <= MAX_LEN, is accepted. One cycle later stat_valid is 1 with stat_code 0 (accepted), and chk_valid is 1 for the first chunk.
- R3: A request sampled while a transfer is running gets stat_valid with stat_code 1 (busy) one cycle later. It is not queued: no extra chunk is issued and the running transfer goes on unchanged.
- R4: A request with req_len 0 or req_len greater than MAX_LEN gets stat_code 2 (bad length) one cycle later. No chunk is issued and req_ready stays 1.
- R5: The first chunk has chk_addr equal to the start address, chk_off equal to the start address modulo LINE_BYTES, and chk_len equal to min(total length, LINE_BYTES - chk_off). chk_line is chk_addr with its low log2(LINE_BYTES) bits cleared.
- R6: Each later chunk has chk_addr equal to the start address plus the bytes completed so far. That address is line-aligned, chk_off is 0, and chk_len is min(remaining bytes, LINE_BYTES).
- R7: chk_store is 1 for every chunk of a write and 0 for every chunk of a read.
- R8: For a write, chk_data byte lane k (bits 8k+7:8k) holds payload byte (completed + k - chk_off) when chk_off <= k < chk_off + chk_len. Every other lane is 0. Payload byte i is req_wdata bits 8i+7:8i.
- R9: At most one chunk is outstanding at any time. A chunk is issued only after the previous one has been answered. While chk_valid is 1 and chk_ready is 0, the chunk fields are held steady.
- R10: For a read, each answering line supplies chk_len bytes, taken from byte lane chk_off onward. They are written to rd_data starting at byte (bytes completed). After the final answer, rd_data byte i equals memory byte (start + i).
- R11: One cycle after the answer that completes the last chunk, done pulses for one cycle and req_ready is already 1. A request presented in that cycle is accepted.
- R12: An acknowledge or a data line that does not answer an outstanding chunk of the matching direction is ignored, and stray pulses one cycle later. rd_data does not change and no chunk is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request attempt this cycle |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_wdata | input | MAX_LEN*8 | Write payload, byte i at bits 8i+7:8i |
| stat_valid | output | 1 | Status for the request of the previous cycle |
| stat_code | output | 2 | 0 accepted, 1 busy, 2 bad length |
| chk_valid | output | 1 | Chunk transaction offered |
| chk_ready | input | 1 | Downstream takes the chunk |
| chk_addr | output | ADDR_W | Full byte address of the chunk |
| chk_line | output | ADDR_W | Line address of the chunk |
| chk_store | output | 1 | 1 store, 0 load |
| chk_off | output | OFFW | First byte lane used in the line |
| chk_len | output | OFFW+1 | Bytes in the chunk |
| chk_data | output | LINE_BYTES*8 | Store data placed at its byte lanes |
| ack_valid | input | 1 | Store acknowledge |
| rdat_valid | input | 1 | Load line returned |
| rdat_line | input | LINE_BYTES*8 | Returned line data |
| done | output | 1 | Transfer completed pulse |
| rd_data | output | MAX_LEN*8 | Byte buffer holding read results |
| stray | output | 1 | Unmatched answer was dropped |

## Verification
The status for a request, and the first chunk of an accepted request, both appear one cycle after the edge that samples req_valid. A chunk taken at an edge drops chk_valid straight after that edge. The answer to a chunk updates rd_data and raises either the next chunk or the done pulse one cycle after it is sampled. The stray flag follows the same one-cycle rule. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each check falls exactly one register stage after its stimulus. The stall checks read the held chunk fields on each falling edge while chk_ready is low.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

   typedef enum logic [1:0] {
      STAT_OK     = 2'd0,
      STAT_BUSY   = 2'd1,
      STAT_BADLEN = 2'd2
   } stat_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ISSUE = 2'd1,
      PH_WAIT  = 2'd2
   } phase_e;

endpackage

// File: rtl/dma_chunk_calc.sv
// Computes the current chunk's address, lane offset and size from the
// transfer start, its length and the bytes already completed.
module dma_chunk_calc #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int LEN_W      = 9
) (
   input  logic [ADDR_W-1:0]               base_addr,
   input  logic [LEN_W-1:0]                total_len,
   input  logic [LEN_W-1:0]                done_bytes,
   output logic [ADDR_W-1:0]               cur_addr,
   output logic [ADDR_W-1:0]               cur_line,
   output logic [$clog2(LINE_BYTES)-1:0]   cur_off,
   output logic [$clog2(LINE_BYTES):0]     cur_len
);
   localparam int OFFW = $clog2(LINE_BYTES);
   localparam int CLW  = OFFW + 1;
   localparam int CW   = ((LEN_W > CLW) ? LEN_W : CLW) + 1;

   logic [CW-1:0] remain;
   logic [CW-1:0] room;

   always_comb begin
      cur_off  = (done_bytes == '0) ? base_addr[OFFW-1:0] : '0;
      cur_addr = base_addr + ADDR_W'(done_bytes);
      cur_line = {cur_addr[ADDR_W-1:OFFW], {OFFW{1'b0}}};
      remain   = CW'(total_len) - CW'(done_bytes);
      room     = CW'(LINE_BYTES) - CW'(cur_off);
      if (remain < room)
         cur_len = CLW'(remain);
      else
         cur_len = CLW'(room);
   end

endmodule

// File: rtl/dma_lane_pack.sv
// Places store payload bytes at their lanes within the line.
module dma_lane_pack #(
   parameter int LINE_BYTES = 64,
   parameter int MAX_LEN    = 256,
   parameter int LEN_W      = 9
) (
   input  logic [MAX_LEN*8-1:0]            buf_q,
   input  logic [LEN_W-1:0]                base_idx,
   input  logic [$clog2(LINE_BYTES)-1:0]   off,
   input  logic [$clog2(LINE_BYTES):0]     len,
   output logic [LINE_BYTES*8-1:0]         line_data
);
   for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
      int          src;
      logic [7:0]  lane_b;
      always_comb begin
         src    = int'(base_idx) + k - int'(off);
         lane_b = 8'h00;
         if ((k >= int'(off)) && (k < int'(off) + int'(len)) &&
             (src >= 0) && (src < MAX_LEN))
            lane_b = buf_q[src*8 +: 8];
      end
      assign line_data[k*8 +: 8] = lane_b;
   end

endmodule

// File: rtl/dma_byte_buf.sv
// Transfer byte buffer: loaded whole for writes, filled line by line for reads.
module dma_byte_buf #(
   parameter int LINE_BYTES = 64,
   parameter int MAX_LEN    = 256,
   parameter int LEN_W      = 9
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_en,
   input  logic [MAX_LEN*8-1:0]            load_data,
   input  logic                            fill_en,
   input  logic [LINE_BYTES*8-1:0]         fill_line,
   input  logic [LEN_W-1:0]                fill_pos,
   input  logic [LEN_W-1:0]                fill_cnt,
   input  logic [$clog2(LINE_BYTES)-1:0]   fill_off,
   output logic [MAX_LEN*8-1:0]            buf_q
);
   for (genvar j = 0; j < MAX_LEN; j++) begin : g_byte
      int         src;
      logic       hit;
      logic [7:0] mem_b;
      always_comb begin
         src = j - int'(fill_pos) + int'(fill_off);
         hit = fill_en && (j >= int'(fill_pos)) &&
               (j < int'(fill_pos) + int'(fill_cnt)) &&
               (src >= 0) && (src < LINE_BYTES);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem_b <= 8'h00;
         else if (load_en)
            mem_b <= load_data[j*8 +: 8];
         else if (hit)
            mem_b <= fill_line[src*8 +: 8];
      end
      assign buf_q[j*8 +: 8] = mem_b;
   end

endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_LEN    = 256,
   localparam int OFFW      = $clog2(LINE_BYTES),
   localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [LEN_W-1:0]          req_len,
   input  logic [MAX_LEN*8-1:0]      req_wdata,
   output logic                      stat_valid,
   output logic [1:0]                stat_code,
   output logic                      chk_valid,
   input  logic                      chk_ready,
   output logic [ADDR_W-1:0]         chk_addr,
   output logic [ADDR_W-1:0]         chk_line,
   output logic                      chk_store,
   output logic [OFFW-1:0]           chk_off,
   output logic [OFFW:0]             chk_len,
   output logic [LINE_BYTES*8-1:0]   chk_data,
   input  logic                      ack_valid,
   input  logic                      rdat_valid,
   input  logic [LINE_BYTES*8-1:0]   rdat_line,
   output logic                      done,
   output logic [MAX_LEN*8-1:0]      rd_data,
   output logic                      stray
);
   import dma_split_pkg::*;

   if ((LINE_BYTES < 4) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (MAX_LEN < 1) begin : g_bad_len
      $error("MAX_LEN must be at least 1");
   end
   if (ADDR_W <= OFFW) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   phase_e              phase_q;
   logic [ADDR_W-1:0]   base_q;
   logic [LEN_W-1:0]    len_q;
   logic                wr_q;
   logic [LEN_W-1:0]    cmpl_q;
   logic [LEN_W-1:0]    iss_q;
   logic                done_q;
   logic                stat_v_q;
   stat_e               stat_q;
   logic                stray_q;

   logic                len_ok;
   logic                accept;
   logic                resp_any;
   logic                resp_hit;
   logic [OFFW:0]       c_len;
   logic [OFFW-1:0]     c_off;
   logic [ADDR_W-1:0]   c_addr;
   logic [ADDR_W-1:0]   c_line;

   assign len_ok   = (req_len != '0) && (int'(req_len) <= MAX_LEN);
   assign accept   = req_valid && (phase_q == PH_IDLE) && len_ok;
   assign resp_any = ack_valid || rdat_valid;
   assign resp_hit = (phase_q == PH_WAIT) && (wr_q ? ack_valid : rdat_valid);

   dma_chunk_calc #(
      .ADDR_W     (ADDR_W),
      .LINE_BYTES (LINE_BYTES),
      .LEN_W      (LEN_W)
   ) u_calc (
      .base_addr  (base_q),
      .total_len  (len_q),
      .done_bytes (cmpl_q),
      .cur_addr   (c_addr),
      .cur_line   (c_line),
      .cur_off    (c_off),
      .cur_len    (c_len)
   );

   dma_byte_buf #(
      .LINE_BYTES (LINE_BYTES),
      .MAX_LEN    (MAX_LEN),
      .LEN_W      (LEN_W)
   ) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (accept && req_write),
      .load_data  (req_wdata),
      .fill_en    (resp_hit && !wr_q),
      .fill_line  (rdat_line),
      .fill_pos   (cmpl_q),
      .fill_cnt   (iss_q - cmpl_q),
      .fill_off   (c_off),
      .buf_q      (rd_data)
   );

   dma_lane_pack #(
      .LINE_BYTES (LINE_BYTES),
      .MAX_LEN    (MAX_LEN),
      .LEN_W      (LEN_W)
   ) u_pack (
      .buf_q      (rd_data),
      .base_idx   (cmpl_q),
      .off        (c_off),
      .len        (c_len),
      .line_data  (chk_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         base_q   <= '0;
         len_q    <= '0;
         wr_q     <= 1'b0;
         cmpl_q   <= '0;
         iss_q    <= '0;
         done_q   <= 1'b0;
         stat_v_q <= 1'b0;
         stat_q   <= STAT_OK;
         stray_q  <= 1'b0;
      end else begin
         stat_v_q <= req_valid;
         if (phase_q != PH_IDLE)
            stat_q <= STAT_BUSY;
         else if (!len_ok)
            stat_q <= STAT_BADLEN;
         else
            stat_q <= STAT_OK;
         done_q  <= 1'b0;
         stray_q <= resp_any && !resp_hit;
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  base_q  <= req_addr;
                  len_q   <= req_len;
                  wr_q    <= req_write;
                  cmpl_q  <= '0;
                  iss_q   <= '0;
                  phase_q <= PH_ISSUE;
               end
            end
            PH_ISSUE: begin
               if (chk_ready) begin
                  iss_q   <= cmpl_q + LEN_W'(c_len);
                  phase_q <= PH_WAIT;
               end
            end
            PH_WAIT: begin
               if (resp_hit) begin
                  cmpl_q <= iss_q;
                  if (iss_q == len_q) begin
                     phase_q <= PH_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     phase_q <= PH_ISSUE;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign req_ready  = (phase_q == PH_IDLE);
   assign stat_valid = stat_v_q;
   assign stat_code  = stat_q;
   assign chk_valid  = (phase_q == PH_ISSUE);
   assign chk_addr   = c_addr;
   assign chk_line   = c_line;
   assign chk_store  = wr_q;
   assign chk_off    = c_off;
   assign chk_len    = c_len;
   assign done       = done_q;
   assign stray      = stray_q;

endmodule

// File: rtl/dma_line_splitter_chk.sv
module dma_line_splitter_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   localparam int OFFW      = $clog2(LINE_BYTES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               stat_valid,
   input logic [1:0]         stat_code,
   input logic               chk_valid,
   input logic               chk_ready,
   input logic [ADDR_W-1:0]  chk_addr,
   input logic [OFFW-1:0]    chk_off,
   input logic [OFFW:0]      chk_len,
   input logic               ack_valid,
   input logic               rdat_valid,
   input logic               done,
   input logic               stray
);
   logic outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         outst_q <= 1'b0;
      else if (chk_valid && chk_ready)
         outst_q <= 1'b1;
      else if (ack_valid || rdat_valid)
         outst_q <= 1'b0;
   end

   AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      outst_q |-> !chk_valid);                                                   // R9
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_addr) && $stable(chk_len))); // R9
   AST_CHUNK_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> ((chk_len != '0) && (int'(chk_off) + int'(chk_len) <= LINE_BYTES))); // R5
   AST_OFF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> (chk_addr[OFFW-1:0] == chk_off));                            // R6
   AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (stat_valid && (stat_code == 2'd1)));        // R3
   AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);                                                       // R11
   AST_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_valid || rdat_valid) && !outst_q) |=> stray);                        // R12

endmodule

bind dma_line_splitter dma_line_splitter_chk #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .stat_valid (stat_valid),
   .stat_code  (stat_code),
   .chk_valid  (chk_valid),
   .chk_ready  (chk_ready),
   .chk_addr   (chk_addr),
   .chk_off    (chk_off),
   .chk_len    (chk_len),
   .ack_valid  (ack_valid),
   .rdat_valid (rdat_valid),
   .done       (done),
   .stray      (stray)
);

// File: tb/sim_dma_line_splitter.sv
module sim_dma_line_splitter;
   localparam int CLK_P = 10;
   localparam int AW    = 32;
   localparam int L     = 64;
   localparam int ML    = 256;
   localparam int OW    = $clog2(L);
   localparam int LW    = $clog2(ML + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [AW-1:0]     req_addr = '0;
   logic [LW-1:0]     req_len = '0;
   logic [ML*8-1:0]   req_wdata = '0;
   logic              stat_valid;
   logic [1:0]        stat_code;
   logic              chk_valid;
   logic              chk_ready = 1'b0;
   logic [AW-1:0]     chk_addr;
   logic [AW-1:0]     chk_line;
   logic              chk_store;
   logic [OW-1:0]     chk_off;
   logic [OW:0]       chk_len;
   logic [L*8-1:0]    chk_data;
   logic              ack_valid = 1'b0;
   logic              rdat_valid = 1'b0;
   logic [L*8-1:0]    rdat_line = '0;
   logic              done;
   logic [ML*8-1:0]   rd_data;
   logic              stray;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   dma_line_splitter #(.ADDR_W(AW), .LINE_BYTES(L), .MAX_LEN(ML)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .req_wdata(req_wdata), .stat_valid(stat_valid), .stat_code(stat_code),
      .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_addr(chk_addr),
      .chk_line(chk_line), .chk_store(chk_store), .chk_off(chk_off),
      .chk_len(chk_len), .chk_data(chk_data), .ack_valid(ack_valid),
      .rdat_valid(rdat_valid), .rdat_line(rdat_line), .done(done),
      .rd_data(rd_data), .stray(stray)
   );

   function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
      return 8'(a * 7 + 3);
   endfunction

   function automatic logic [7:0] pay_b(input int i);
      return 8'(i * 13 + 5);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_payload();
      for (int i = 0; i < ML; i++) req_wdata[i*8 +: 8] = pay_b(i);
   endtask

   // One full transfer with a responder; returns on the falling edge where done is high.
   task automatic run_xfer(input logic [AW-1:0] addr, input int len, input bit wr,
                           input int stall, input bit poke);
      int cmp = 0;
      bit first = 1'b1;
      bit do_poke = poke;
      set_payload();
      req_addr = addr; req_len = LW'(len); req_write = wr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(stat_valid && stat_code == 2'd0, "R2", "accept status", stat_code, 0);
      while (cmp < len) begin
         int off = first ? int'(addr % L) : 0;
         int rem = len - cmp;
         int cl  = (rem < L - off) ? rem : L - off;
         logic [AW-1:0] ea = addr + AW'(cmp);
         check(chk_valid, first ? "R2" : "R6", "chunk valid", chk_valid, 1);
         check(chk_addr == ea, first ? "R5" : "R6", "chunk addr", chk_addr, ea);
         check(chk_line == (ea & ~AW'(L - 1)), first ? "R5" : "R6", "line addr", chk_line, ea & ~AW'(L - 1));
         check(int'(chk_off) == off && int'(chk_len) == cl, first ? "R5" : "R6",
               "off/len", {chk_off, 8'(chk_len)}, {8'(off), 8'(cl)});
         check(chk_store == wr, "R7", "store type", chk_store, wr);
         if (wr) begin
            int bad = -1;
            for (int k = 0; k < L; k++) begin
               logic [7:0] e = (k >= off && k < off + cl) ? pay_b(cmp + k - off) : 8'h00;
               if (chk_data[k*8 +: 8] !== e && bad < 0) bad = k;
            end
            check(bad < 0, "R8", "store lane", bad, -1);
         end
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(chk_valid && chk_addr == ea && int'(chk_len) == cl, "R9", "held chunk", chk_addr, ea);
         end
         chk_ready = 1'b1;
         @(negedge clk);
         chk_ready = 1'b0;
         check(!chk_valid, "R9", "no second chunk before answer", chk_valid, 0);
         if (do_poke) begin
            req_addr = 32'h0; req_len = LW'(8); req_write = 1'b0; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check(stat_valid && stat_code == 2'd1, "R3", "busy status", stat_code, 1);
            check(!chk_valid && !req_ready, "R3", "not queued", chk_valid, 0);
            do_poke = 1'b0;
         end
         if (wr) ack_valid = 1'b1;
         else begin
            for (int k = 0; k < L; k++) rdat_line[k*8 +: 8] = mem_b((ea & ~AW'(L - 1)) + AW'(k));
            rdat_valid = 1'b1;
         end
         @(negedge clk);
         ack_valid = 1'b0; rdat_valid = 1'b0;
         cmp += cl; first = 1'b0;
         if (cmp < len) check(!done, "R11", "early done", done, 0);
      end
      check(done && req_ready, "R11", "done with ready", {done, req_ready}, 2'b11);
      if (!wr) begin
         int bad = -1;
         for (int i = 0; i < len; i++)
            if (rd_data[i*8 +: 8] !== mem_b(addr + AW'(i)) && bad < 0) bad = i;
         check(bad < 0, "R10", "read byte", bad, -1);
      end
   endtask

   task automatic t_reset();
      check(req_ready && !chk_valid && !done && !stat_valid && !stray, "R1", "reset outputs",
            {req_ready, chk_valid, done, stat_valid, stray}, 5'b10000);
   endtask

   task automatic t_badlen(input int len);
      req_addr = 32'h500; req_len = LW'(len); req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(stat_valid && stat_code == 2'd2, "R4", "bad length status", stat_code, 2);
      check(!chk_valid && req_ready, "R4", "no chunk", chk_valid, 0);
      @(negedge clk);
   endtask

   task automatic t_stray();
      logic [ML*8-1:0] snap = rd_data;
      rdat_line = '1; rdat_valid = 1'b1;
      @(negedge clk);
      rdat_valid = 1'b0;
      check(stray && !chk_valid && req_ready, "R12", "stray data", stray, 1);
      check(rd_data == snap, "R12", "buffer kept", 0, 0);
      ack_valid = 1'b1;
      @(negedge clk);
      ack_valid = 1'b0;
      check(stray && !chk_valid, "R12", "stray ack", stray, 1);
      @(negedge clk);
      check(!stray, "R12", "stray clears", stray, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_xfer(32'h1030, 100, 1'b1, 0, 1'b0); @(negedge clk);
      run_xfer(32'h2005, 200, 1'b0, 2, 1'b0); @(negedge clk);
      run_xfer(32'h300A, 20, 1'b0, 0, 1'b0); @(negedge clk);
      run_xfer(32'h4000, 256, 1'b1, 0, 1'b1); @(negedge clk);
      t_badlen(0);
      t_badlen(257);
      run_xfer(32'h5033, 70, 1'b0, 1, 1'b1);
      run_xfer(32'h6010, 90, 1'b1, 1, 1'b0);
      @(negedge clk);
      t_stray();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule